// File: doc/BRIEF.md
# Hash Engine Control Registers

This block is the register front end of a hashing accelerator. Software programs a source address, a destination address and a source length, then writes a command word. The block decodes the algorithm selection in that word. A legal selection issues a one-cycle start pulse to the digest engine and the data fetcher, together with a compact algorithm code. Any other selection raises a sticky error flag and starts nothing.

When the engine reports completion, the block sets a completion flag in its status register. It raises the interrupt line only if the command that started the operation asked for it. Software clears the completion flag, and with it the interrupt, by writing a one to that bit.

While an operation is running, the block refuses new commands. A refused command leaves the stored command unchanged and sets a sticky drop flag. Register accesses are 32 bits wide. The block accepts an access in every cycle, and read data is valid in the same cycle as the read request.

Top module: `hash_cmd_regs`

## Requirements
- R1: After reset every register reads zero, `irq` and `engStart` are low, and `engAlgo` is 0.
- R2: A write to offset 0x20 stores the data ANDed with 0x7FFFFFFF. A write to 0x24 stores the data ANDed with 0x7FFFFFF8. A write to 0x2C stores all 32 bits. Each value reads back at its own offset.
- R3: A write to offset 0x30 that is accepted stores the data ANDed with 0x00147FFF, and that value reads back at 0x30.
- R4: An accepted command with a legal selection pulses `engStart` for exactly one cycle, starting the cycle after the write. The selection is formed by primary field bits [6:4] and family field bits [12:10]. The `engAlgo` codes are:
  - primary 000 with family 000 gives code 0.
  - primary 010 with family 000 gives code 1.
  - primary 100 with family 000 gives code 2.
  - primary 101 with family 000 gives code 3.
  - primary 011 gives codes 4, 5, 6 and 7 for family 000, 001, 010 and 011 respectively.
- R5: An accepted command with any other combination of bits [12:10] and [6:4] starts nothing and sets status bit 0.
- R6: An accepted command with any of bits 8, 7, 1 or 0 set starts nothing and sets status bit 1. This check takes precedence over the algorithm check.
- R7: `engSgMode` follows bit 18 of the stored command. `engSrcAddr`, `engDstAddr` and `engSrcLen` follow the stored register values.
- R8: Status bit 31 reads 1 from the start pulse until `engDone` is seen. A command written during that time is dropped: nothing starts, the stored command is unchanged, and status bit 2 is set. `engDone` while idle has no effect.
- R9: `engDone` during an operation sets status bit 9 whether or not command bit 9 is set. `irq` rises in the next cycle only if command bit 9 is set.
- R10: Writing a 1 to status bit 9, 2, 1 or 0 at offset 0x1C clears that bit. Clearing bit 9 while it is set also lowers `irq`. Writing 0 to a bit changes nothing. A completion in the same cycle as the clear leaves bit 9 and `irq` set.
- R11: `busReady` is always high. Reads of any offset other than 0x1C, 0x20, 0x24, 0x2C and 0x30 return zero, including 0x10. Writes to those offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Register access request |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busReady | output | 1 | Access accepted (always high) |
| busRdata | output | 32 | Read data, valid in the same cycle as the read |
| engStart | output | 1 | One-cycle start pulse to the engine |
| engAlgo | output | 3 | Algorithm code for the started operation |
| engSgMode | output | 1 | Source is a scatter-gather list |
| engSrcAddr | output | 32 | Masked source address |
| engDstAddr | output | 32 | Masked, 8-byte-aligned destination address |
| engSrcLen | output | 32 | Source length |
| engDone | input | 1 | Engine completion strobe |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions check three things on every cycle:
- The start pulse lasts one cycle, no start follows a command refused while busy, and the stored command is frozen during an operation.
- Completion always sets the status flag and clears busy.
- `irq` can only rise under an enabled command, and a write-one-clear drops both the flag and `irq` when no completion coincides.

Only the bench's scenarios can show the rest. This includes the full algorithm table and its illegal corners, the precedence of the unsupported-mode check, and the address masks. It also covers reads of unmapped offsets, a completion while idle, and a completion that coincides with a clear.

// File: rtl/hash_regs_pkg.sv
package hash_regs_pkg;

  // byte offsets the block decodes
  localparam int OFF_STATUS = 'h1C;
  localparam int OFF_SRC    = 'h20;
  localparam int OFF_DST    = 'h24;
  localparam int OFF_LEN    = 'h2C;
  localparam int OFF_CMD    = 'h30;

  // status bit positions
  localparam int ST_BAD   = 0;
  localparam int ST_UNSUP = 1;
  localparam int ST_DROP  = 2;
  localparam int ST_DONE  = 9;
  localparam int ST_BUSY  = 31;

  // command bit positions
  localparam int CMD_IRQ_EN = 9;
  localparam int CMD_SG     = 18;

  typedef struct packed {
    logic loadCmd;
    logic startOp;
    logic flagBad;
    logic flagUnsup;
    logic flagDrop;
    logic opDone;
  } ctrlStrobes_t;

  typedef struct packed {
    logic       ok;
    logic [2:0] id;
  } algoSel_t;

  function automatic algoSel_t decodeAlgo(input logic [2:0] prim, input logic [2:0] fam);
    algoSel_t s;
    s = '{ok: 1'b0, id: 3'd0};
    if (prim == 3'b011) begin
      if (fam[2] == 1'b0) s = '{ok: 1'b1, id: {1'b1, fam[1:0]}};
    end else if (fam == 3'b000) begin
      case (prim)
        3'b000: s = '{ok: 1'b1, id: 3'd0};
        3'b010: s = '{ok: 1'b1, id: 3'd1};
        3'b100: s = '{ok: 1'b1, id: 3'd2};
        3'b101: s = '{ok: 1'b1, id: 3'd3};
        default: s = '{ok: 1'b0, id: 3'd0};
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/hash_regs_ctrl.sv
module hash_regs_ctrl
  import hash_regs_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [2:0]        algoPrim,
  input  logic [2:0]        algoFam,
  input  logic [3:0]        modeBits,
  input  logic              engDone,
  output ctrlStrobes_t      strobes,
  output logic              busy,
  output logic              engStart,
  output logic [2:0]        engAlgo
);

  logic     cmdWr;
  logic     unsupMode;
  algoSel_t sel;

  assign cmdWr     = busValid && busWrite && (busAddr == ADDR_W'(OFF_CMD));
  assign unsupMode = |modeBits;
  assign sel       = decodeAlgo(algoPrim, algoFam);

  always_comb begin
    strobes           = '0;
    strobes.loadCmd   = cmdWr && !busy;
    strobes.flagDrop  = cmdWr && busy;
    strobes.flagUnsup = strobes.loadCmd && unsupMode;
    strobes.flagBad   = strobes.loadCmd && !unsupMode && !sel.ok;
    strobes.startOp   = strobes.loadCmd && !unsupMode && sel.ok;
    strobes.opDone    = engDone && busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      engStart <= 1'b0;
      engAlgo  <= 3'd0;
    end else begin
      engStart <= strobes.startOp;
      if (strobes.startOp) begin
        busy    <= 1'b1;
        engAlgo <= sel.id;
      end else if (strobes.opDone) begin
        busy <= 1'b0;
      end
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart); // R4
  AST_DROP_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busy) |=> !engStart); // R8
  AST_DONE_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    (engDone && busy) |=> !busy); // R8
  AST_START_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    engStart |-> busy); // R8

endmodule

// File: rtl/hash_regs_dp.sv
module hash_regs_dp
  import hash_regs_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] SRC_MASK = 32'h7FFF_FFFF,
  parameter logic [31:0] DST_MASK = 32'h7FFF_FFF8,
  parameter logic [31:0] CMD_MASK = 32'h0014_7FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  ctrlStrobes_t      strobes,
  input  logic              busy,
  output logic [31:0]       busRdata,
  output logic [31:0]       srcQ,
  output logic [31:0]       dstQ,
  output logic [31:0]       lenQ,
  output logic [31:0]       cmdQ,
  output logic              irq
);

  localparam int NUM_FLAGS = 4;
  localparam int FLAG_POS [NUM_FLAGS] = '{ST_BAD, ST_UNSUP, ST_DROP, ST_DONE};
  localparam int DONE_IDX = NUM_FLAGS - 1;

  logic                 wr;
  logic                 stWr;
  logic [NUM_FLAGS-1:0] flagSet;
  logic [NUM_FLAGS-1:0] flagQ;
  logic [31:0]          statusVal;

  assign wr      = busValid && busWrite;
  assign stWr    = wr && (busAddr == ADDR_W'(OFF_STATUS));
  assign flagSet = {strobes.opDone, strobes.flagDrop, strobes.flagUnsup, strobes.flagBad};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ <= '0;
      dstQ <= '0;
      lenQ <= '0;
      cmdQ <= '0;
    end else begin
      if (wr && busAddr == ADDR_W'(OFF_SRC)) srcQ <= busWdata & SRC_MASK;
      if (wr && busAddr == ADDR_W'(OFF_DST)) dstQ <= busWdata & DST_MASK;
      if (wr && busAddr == ADDR_W'(OFF_LEN)) lenQ <= busWdata;
      if (strobes.loadCmd)                   cmdQ <= busWdata & CMD_MASK;
    end
  end

  // sticky flags: a set from the control side wins over a clear from software
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                               flagQ[g] <= 1'b0;
      else if (flagSet[g])                     flagQ[g] <= 1'b1;
      else if (stWr && busWdata[FLAG_POS[g]])  flagQ[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                             irq <= 1'b0;
    else if (strobes.opDone && cmdQ[CMD_IRQ_EN])           irq <= 1'b1;
    else if (stWr && busWdata[ST_DONE] && flagQ[DONE_IDX]) irq <= 1'b0;
  end

  always_comb begin
    statusVal = '0;
    for (int k = 0; k < NUM_FLAGS; k++) statusVal[FLAG_POS[k]] = flagQ[k];
    statusVal[ST_BUSY] = busy;
  end

  always_comb begin
    busRdata = '0;
    if (busValid && !busWrite) begin
      case (int'(busAddr))
        OFF_STATUS: busRdata = statusVal;
        OFF_SRC:    busRdata = srcQ;
        OFF_DST:    busRdata = dstQ;
        OFF_LEN:    busRdata = lenQ;
        OFF_CMD:    busRdata = cmdQ;
        default:    busRdata = '0;
      endcase
    end
  end

  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strobes.opDone |=> flagQ[DONE_IDX]); // R9
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> cmdQ[CMD_IRQ_EN]); // R9
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (stWr && busWdata[ST_DONE] && !strobes.opDone) |=> (!flagQ[DONE_IDX] && !irq)); // R10
  AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cmdQ)); // R8

endmodule

// File: rtl/hash_cmd_regs.sv
module hash_cmd_regs
  import hash_regs_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] SRC_MASK = 32'h7FFF_FFFF,
  parameter logic [31:0] DST_MASK = 32'h7FFF_FFF8,
  parameter logic [31:0] CMD_MASK = 32'h0014_7FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic              busReady,
  output logic [31:0]       busRdata,
  output logic              engStart,
  output logic [2:0]        engAlgo,
  output logic              engSgMode,
  output logic [31:0]       engSrcAddr,
  output logic [31:0]       engDstAddr,
  output logic [31:0]       engSrcLen,
  input  logic              engDone,
  output logic              irq
);

  ctrlStrobes_t strobes;
  logic         busy;
  logic [31:0]  cmdQ;

  assign busReady = 1'b1;

  hash_regs_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .algoPrim (busWdata[6:4]),
    .algoFam  (busWdata[12:10]),
    .modeBits ({busWdata[8:7], busWdata[1:0]}),
    .engDone  (engDone),
    .strobes  (strobes),
    .busy     (busy),
    .engStart (engStart),
    .engAlgo  (engAlgo)
  );

  hash_regs_dp #(
    .ADDR_W   (ADDR_W),
    .SRC_MASK (SRC_MASK),
    .DST_MASK (DST_MASK),
    .CMD_MASK (CMD_MASK)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .strobes  (strobes),
    .busy     (busy),
    .busRdata (busRdata),
    .srcQ     (engSrcAddr),
    .dstQ     (engDstAddr),
    .lenQ     (engSrcLen),
    .cmdQ     (cmdQ),
    .irq      (irq)
  );

  assign engSgMode = cmdQ[CMD_SG];

endmodule

// File: tb/tb_hash_cmd_regs.sv
module tb_hash_cmd_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busReady;
  logic [31:0] busRdata;
  logic        engStart;
  logic [2:0]  engAlgo;
  logic        engSgMode;
  logic [31:0] engSrcAddr, engDstAddr, engSrcLen;
  logic        engDone = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  hash_cmd_regs dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busReady(busReady),
    .busRdata(busRdata), .engStart(engStart), .engAlgo(engAlgo),
    .engSgMode(engSgMode), .engSrcAddr(engSrcAddr), .engDstAddr(engDstAddr),
    .engSrcLen(engSrcLen), .engDone(engDone), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference for the per-cycle outputs
  logic [31:0] mCmd;
  logic        mBusy, mIrq, mStart, mDone;
  logic [2:0]  mAlgo;

  function automatic logic [3:0] refAlgo(input logic [31:0] c);
    case ({c[12:10], c[6:4]})
      6'b000_000: return 4'b1000;
      6'b000_010: return 4'b1001;
      6'b000_100: return 4'b1010;
      6'b000_101: return 4'b1011;
      6'b000_011: return 4'b1100;
      6'b001_011: return 4'b1101;
      6'b010_011: return 4'b1110;
      6'b011_011: return 4'b1111;
      default:    return 4'b0000;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCmd = 0; mBusy = 0; mIrq = 0; mStart = 0; mDone = 0; mAlgo = 0;
    end else begin
      automatic logic wasBusy = mBusy;
      automatic logic nextStart = 1'b0;
      automatic logic [3:0] a;
      if (busValid && busWrite) begin
        if (busAddr == 12'h01C && busWdata[9]) begin
          if (mDone) mIrq = 1'b0;
          mDone = 1'b0;
        end
        if (busAddr == 12'h030 && !wasBusy) begin
          mCmd = busWdata & 32'h0014_7FFF;
          a = refAlgo(mCmd);
          if (mCmd[8:7] == 0 && mCmd[1:0] == 0 && a[3]) begin
            nextStart = 1'b1; mBusy = 1'b1; mAlgo = a[2:0];
          end
        end
      end
      if (engDone && wasBusy) begin
        mBusy = 1'b0; mDone = 1'b1;
        if (mCmd[9]) mIrq = 1'b1;
      end
      mStart = nextStart;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk("R4 engStart per cycle", {31'd0, engStart}, {31'd0, mStart});
      chk("R4 engAlgo per cycle", {29'd0, engAlgo}, {29'd0, mAlgo});
      chk("R9 irq per cycle", {31'd0, irq}, {31'd0, mIrq});
      chk("R11 busReady", {31'd0, busReady}, 32'd1);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 chk(req, busRdata, exp);
    @(posedge clk); #1;
    busValid = 1'b0;
  endtask

  task automatic finishOp();
    @(negedge clk);
    engDone = 1'b1;
    @(posedge clk); #1;
    engDone = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rd(12'h01C, 0, "R1 status");
    rd(12'h020, 0, "R1 src");
    rd(12'h024, 0, "R1 dst");
    rd(12'h02C, 0, "R1 len");
    rd(12'h030, 0, "R1 cmd");
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 engStart", {31'd0, engStart}, 0);

    // R2 masking
    wr(12'h020, 32'hFFFF_FFFF); rd(12'h020, 32'h7FFF_FFFF, "R2 src mask");
    wr(12'h024, 32'hFFFF_FFFF); rd(12'h024, 32'h7FFF_FFF8, "R2 dst mask");
    wr(12'h02C, 32'hDEAD_BEEF); rd(12'h02C, 32'hDEAD_BEEF, "R2 len");
    chk("R7 engSrcAddr", engSrcAddr, 32'h7FFF_FFFF);
    chk("R7 engDstAddr", engDstAddr, 32'h7FFF_FFF8);
    chk("R7 engSrcLen", engSrcLen, 32'hDEAD_BEEF);

    // R11 unmapped offsets
    wr(12'h040, 32'h1234_5678); rd(12'h040, 0, "R11 unmapped read");
    wr(12'h010, 32'h0000_AAAA); rd(12'h010, 0, "R11 cipher offset read");
    rd(12'h020, 32'h7FFF_FFFF, "R11 write elsewhere leaves src");
    rd(12'h01C, 0, "R11 status untouched");

    // R3 and R6: all-ones command is masked and unsupported
    wr(12'h030, 32'hFFFF_FFFF);
    chk("R6 no start", {31'd0, engStart}, 0);
    rd(12'h030, 32'h0014_7FFF, "R3 cmd mask");
    rd(12'h01C, 32'h0000_0002, "R6 unsupported flag");
    wr(12'h01C, 32'h0000_0002); rd(12'h01C, 0, "R10 clear bit1");
    wr(12'h030, 32'h0000_0081); // bit7 + bit0 with an md5 selection
    rd(12'h01C, 32'h0000_0002, "R6 precedence over algorithm");
    wr(12'h01C, 32'h0000_0002);

    // R4 / R9: every legal selection, irq enabled on even codes
    for (int i = 0; i < 8; i++) begin
      automatic logic [31:0] c;
      automatic logic en = (i % 2 == 0);
      case (i)
        0: c = 32'h0000_0000;
        1: c = 32'h0000_0020;
        2: c = 32'h0000_0040;
        3: c = 32'h0000_0050;
        4: c = 32'h0000_0030;
        5: c = 32'h0000_0430;
        6: c = 32'h0000_0830;
        default: c = 32'h0000_0C30;
      endcase
      if (en) c = c | 32'h0000_0200;
      wr(12'h030, c);
      chk("R4 start pulse", {31'd0, engStart}, 1);
      chk("R4 algorithm code", {29'd0, engAlgo}, i);
      rd(12'h01C, 32'h8000_0000, "R8 busy flag");
      finishOp();
      rd(12'h01C, 32'h0000_0200, "R9 done set regardless of enable");
      chk("R9 irq follows enable", {31'd0, irq}, {31'd0, en});
      wr(12'h01C, 32'h0000_0200);
      rd(12'h01C, 0, "R10 done cleared");
      chk("R10 irq lowered", {31'd0, irq}, 0);
    end

    // R5 invalid selections
    wr(12'h030, 32'h0000_0010);
    chk("R5 no start prim 001", {31'd0, engStart}, 0);
    rd(12'h01C, 32'h0000_0001, "R5 bad flag prim 001");
    wr(12'h01C, 32'h0000_0001);
    wr(12'h030, 32'h0000_0400);
    rd(12'h01C, 32'h0000_0001, "R5 family bits with md5");
    wr(12'h01C, 32'h0000_0001);
    wr(12'h030, 32'h0000_1030);
    rd(12'h01C, 32'h0000_0001, "R5 family 100");
    wr(12'h01C, 32'h0000_0001);
    rd(12'h01C, 0, "R10 bad flag cleared");

    // R7 scatter-gather bit
    wr(12'h030, 32'h0004_0020);
    chk("R7 engSgMode", {31'd0, engSgMode}, 1);
    finishOp();
    wr(12'h01C, 32'h0000_0200);

    // R8 drop while busy
    wr(12'h030, 32'h0000_0250);
    wr(12'h030, 32'h0000_0020);
    chk("R8 dropped command no start", {31'd0, engStart}, 0);
    rd(12'h030, 32'h0000_0250, "R8 cmd unchanged");
    rd(12'h01C, 32'h8000_0004, "R8 drop flag and busy");
    finishOp();
    rd(12'h01C, 32'h0000_0204, "R9 done after drop");
    chk("R9 irq raised", {31'd0, irq}, 1);
    finishOp();
    rd(12'h01C, 32'h0000_0204, "R8 idle done ignored");
    wr(12'h01C, 32'h0000_0000);
    rd(12'h01C, 32'h0000_0204, "R10 zero write no effect");
    chk("R10 irq held by zero write", {31'd0, irq}, 1);
    wr(12'h01C, 32'h0000_0004);
    rd(12'h01C, 32'h0000_0200, "R10 clear drop only");
    chk("R10 irq held by drop clear", {31'd0, irq}, 1);
    wr(12'h01C, 32'h0000_0200);
    chk("R10 irq lowered", {31'd0, irq}, 0);

    // R10 completion coinciding with clear
    wr(12'h030, 32'h0000_0250);
    finishOp();
    wr(12'h030, 32'h0000_0250);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = 12'h01C; busWdata = 32'h0000_0200;
    engDone = 1'b1;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0; engDone = 1'b0;
    rd(12'h01C, 32'h0000_0200, "R10 set wins over clear");
    chk("R10 irq stays", {31'd0, irq}, 1);
    wr(12'h01C, 32'h0000_0200);
    rd(12'h01C, 0, "R10 final clear");

    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule